// File: doc/BRIEF.md
# Transaction ID Filter for Memory Traffic Events

This block qualifies memory traffic by its AXI ID before a performance counter counts it. It watches three channels: the read address handshake, the write address handshake and the read data beats. For each one it raises a single-cycle pulse when the beat's ID agrees with a programmed match ID on every bit that a programmed mask selects. Each of the three pulses is meant for one particular counter, which selects it under one shared event code. Counter storage and interrupts live elsewhere.

Software sets the filter through two 32-bit configuration words. The first word holds the three per-channel enables and the ID mask. The second word holds the ID to match. The enables also follow the event programming of the three counters they serve. Giving one of those counters the filter event code turns its enable on. Giving it any other code turns the enable off. The pulses are combinational in the strobe cycle. Configuration changes take effect from the following cycle.

Top module: `axi_id_filter`

## Requirements
- R1: After reset both configuration words read as zero and all three pulse outputs are low.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata` bit 31 (read-transaction enable), bit 30 (write-transaction enable), bit 29 (read-beat enable) and bits 17:0 (ID mask). A write with `cfg_sel`=1 stores bits 17:0 as the match ID. All other bits read back as zero. `cfg_rdata` shows the word chosen by `cfg_sel`.
- R3: An ID matches when ((ID XOR match ID) AND mask) is zero. A mask bit of 0 makes that ID bit irrelevant.
- R4: `rd_txn_hit` is high in exactly those cycles where `ar_valid` and `ar_ready` are both high, the read-transaction enable is set and `ar_id` matches.
- R5: `wr_txn_hit` is high in exactly those cycles where `aw_valid` and `aw_ready` are both high, the write-transaction enable is set and `aw_id` matches.
- R6: `rd_beat_hit` is high once for each read data beat (`r_valid` and `r_ready`) whose `r_id` matches while the read-beat enable is set. Back-to-back beats give back-to-back pulses.
- R7: While a channel's enable is clear, its pulse output stays low whatever that channel carries.
- R8: Programming counter 2 with event code 73 sets the read-transaction enable, and any other code clears it. Counter 3 does the same for the write-transaction enable and counter 4 for the read-beat enable. Programming any other counter changes no enable.
- R9: A configuration write or counter programming affects filtering and readback from the next cycle. A strobe in the same cycle uses the old settings.
- R10: When a first-word write and a counter programming that touches an enable occur in the same cycle, the programming decides that enable. The write decides the rest of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 enables and mask, 1 match ID |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected word |
| prog_valid | input | 1 | Counter event programming strobe |
| prog_counter | input | 8 | Index of the counter being programmed |
| prog_code | input | 8 | Event code given to that counter |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 18 | Read address ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 18 | Write address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | 18 | Read data ID |
| rd_txn_hit | output | 1 | Filtered read-transaction pulse |
| wr_txn_hit | output | 1 | Filtered write-transaction pulse |
| rd_beat_hit | output | 1 | Filtered read-beat pulse |

## Verification
On every cycle, the assertions check that a pulse appears only with a completed handshake, a set enable and a masked ID match. They also check that the stored settings move only when a write or a programming strobe is present, and that event programming drives each enable to its stated value in the following cycle. The bench scenarios cover the rest. These include the exact readback layout, the don't-care effect of partial masks and the use of old settings in the write cycle. They also include the precedence of programming over a simultaneous word write and the absence of effect from programming unrelated counters.

// File: rtl/axi_id_filter.sv
`timescale 1ns/1ps
module axi_id_filter #(
  parameter int ID_W      = 18,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int FILT_CODE = 73,
  parameter int RD_CNT    = 2,
  parameter int WR_CNT    = 3,
  parameter int BEAT_CNT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              prog_valid,
  input  logic [CNT_W-1:0]  prog_counter,
  input  logic [CNT_W-1:0]  prog_code,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              rd_txn_hit,
  output logic              wr_txn_hit,
  output logic              rd_beat_hit
);
  localparam int BIT_RD   = DATA_W - 1;
  localparam int BIT_WR   = DATA_W - 2;
  localparam int BIT_BEAT = DATA_W - 3;
  localparam int PAD_A    = DATA_W - 3 - ID_W;
  localparam int PAD_B    = DATA_W - ID_W;

  logic [ID_W-1:0] id_mask, id_match;
  logic            en_rd, en_wr, en_beat;
  logic [ID_W-1:0] id_mask_d, id_match_d;
  logic            en_rd_d, en_wr_d, en_beat_d;

  logic wr_word0, wr_word1, filt_evt;
  assign wr_word0 = cfg_we && !cfg_sel;
  assign wr_word1 = cfg_we && cfg_sel;
  assign filt_evt = (prog_code == CNT_W'(FILT_CODE));

  always_comb begin
    id_mask_d  = wr_word0 ? cfg_wdata[ID_W-1:0] : id_mask;
    id_match_d = wr_word1 ? cfg_wdata[ID_W-1:0] : id_match;
    en_rd_d    = wr_word0 ? cfg_wdata[BIT_RD]   : en_rd;
    en_wr_d    = wr_word0 ? cfg_wdata[BIT_WR]   : en_wr;
    en_beat_d  = wr_word0 ? cfg_wdata[BIT_BEAT] : en_beat;
    if (prog_valid) begin
      if (prog_counter == CNT_W'(RD_CNT))   en_rd_d   = filt_evt;
      if (prog_counter == CNT_W'(WR_CNT))   en_wr_d   = filt_evt;
      if (prog_counter == CNT_W'(BEAT_CNT)) en_beat_d = filt_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_mask  <= '0;
      id_match <= '0;
      en_rd    <= 1'b0;
      en_wr    <= 1'b0;
      en_beat  <= 1'b0;
    end else begin
      id_mask  <= id_mask_d;
      id_match <= id_match_d;
      en_rd    <= en_rd_d;
      en_wr    <= en_wr_d;
      en_beat  <= en_beat_d;
    end
  end

  function automatic logic id_ok(input logic [ID_W-1:0] id,
                                 input logic [ID_W-1:0] ref_id,
                                 input logic [ID_W-1:0] msk);
    return ((id ^ ref_id) & msk) == '0;
  endfunction

  assign rd_txn_hit  = en_rd   && ar_valid && ar_ready && id_ok(ar_id, id_match, id_mask);
  assign wr_txn_hit  = en_wr   && aw_valid && aw_ready && id_ok(aw_id, id_match, id_mask);
  assign rd_beat_hit = en_beat && r_valid  && r_ready  && id_ok(r_id,  id_match, id_mask);

  assign cfg_rdata = cfg_sel ? {{PAD_B{1'b0}}, id_match}
                             : {en_rd, en_wr, en_beat, {PAD_A{1'b0}}, id_mask};
endmodule

// File: rtl/axi_id_filter_chk.sv
`timescale 1ns/1ps
module axi_id_filter_chk #(
  parameter int ID_W      = 18,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int FILT_CODE = 73,
  parameter int RD_CNT    = 2,
  parameter int WR_CNT    = 3,
  parameter int BEAT_CNT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              prog_valid,
  input logic [CNT_W-1:0]  prog_counter,
  input logic [CNT_W-1:0]  prog_code,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ID_W-1:0]   ar_id,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ID_W-1:0]   aw_id,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic              rd_txn_hit,
  input logic              wr_txn_hit,
  input logic              rd_beat_hit,
  input logic [ID_W-1:0]   id_mask,
  input logic [ID_W-1:0]   id_match,
  input logic              en_rd,
  input logic              en_wr,
  input logic              en_beat
);
  p_rd_hit_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_txn_hit |-> (ar_valid && ar_ready && en_rd && (((ar_id ^ id_match) & id_mask) == '0)));
  p_wr_hit_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txn_hit |-> (aw_valid && aw_ready && en_wr && (((aw_id ^ id_match) & id_mask) == '0)));
  p_beat_hit_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat_hit |-> (r_valid && r_ready && en_beat && (((r_id ^ id_match) & id_mask) == '0)));
  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rd && !en_wr && !en_beat) |-> !(rd_txn_hit || wr_txn_hit || rd_beat_hit));
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (id_mask == $past(cfg_wdata[ID_W-1:0])));
  p_prog_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && prog_counter == CNT_W'(RD_CNT)) |=> (en_rd == ($past(prog_code) == CNT_W'(FILT_CODE))));
  p_prog_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && prog_counter == CNT_W'(WR_CNT)) |=> (en_wr == ($past(prog_code) == CNT_W'(FILT_CODE))));
  p_prog_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && prog_counter == CNT_W'(BEAT_CNT)) |=> (en_beat == ($past(prog_code) == CNT_W'(FILT_CODE))));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !prog_valid) |=> ($stable(id_mask) && $stable(id_match) && $stable(en_rd)
                                  && $stable(en_wr) && $stable(en_beat)));
endmodule

bind axi_id_filter axi_id_filter_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FILT_CODE(FILT_CODE),
  .RD_CNT(RD_CNT), .WR_CNT(WR_CNT), .BEAT_CNT(BEAT_CNT)
) u_chk (.*);

// File: tb/axi_id_filter_tb_top.sv
`timescale 1ns/1ps
module axi_id_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        prog_valid = 1'b0;
  logic [7:0]  prog_counter = '0, prog_code = '0;
  logic        ar_valid = 1'b0, ar_ready = 1'b0;
  logic [17:0] ar_id = '0;
  logic        aw_valid = 1'b0, aw_ready = 1'b0;
  logic [17:0] aw_id = '0;
  logic        r_valid = 1'b0, r_ready = 1'b0;
  logic [17:0] r_id = '0;
  logic        rd_txn_hit, wr_txn_hit, rd_beat_hit;

  always #10 clk = ~clk;

  axi_id_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prog_valid(prog_valid),
    .prog_counter(prog_counter), .prog_code(prog_code),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .rd_txn_hit(rd_txn_hit), .wr_txn_hit(wr_txn_hit), .rd_beat_hit(rd_beat_hit));

  typedef struct {
    string       tag;
    logic [2:0]  hits;
    logic [31:0] rdata;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the settings
  logic        m_en_rd = 0, m_en_wr = 0, m_en_beat = 0;
  logic [17:0] m_mask = '0, m_match = '0;

  function automatic logic mm(input logic [17:0] id);
    return ((id ^ m_match) & m_mask) == 18'd0;
  endfunction

  task automatic step(input string tag, input logic we, input logic sel, input logic [31:0] wd,
                      input logic pv, input logic [7:0] pc, input logic [7:0] pcode,
                      input logic arv, input logic arr, input logic [17:0] arid,
                      input logic awv, input logic awr, input logic [17:0] awid,
                      input logic rv, input logic rr, input logic [17:0] rid);
    exp_t e;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    prog_valid = pv; prog_counter = pc; prog_code = pcode;
    ar_valid = arv; ar_ready = arr; ar_id = arid;
    aw_valid = awv; aw_ready = awr; aw_id = awid;
    r_valid = rv; r_ready = rr; r_id = rid;
    e.tag = tag;
    e.hits = {m_en_rd && arv && arr && mm(arid),
              m_en_wr && awv && awr && mm(awid),
              m_en_beat && rv && rr && mm(rid)};
    e.rdata = sel ? {14'd0, m_match} : {m_en_rd, m_en_wr, m_en_beat, 11'd0, m_mask};
    q.push_back(e);
    if (we && !sel) begin
      m_en_rd = wd[31]; m_en_wr = wd[30]; m_en_beat = wd[29]; m_mask = wd[17:0];
    end
    if (we && sel) m_match = wd[17:0];
    if (pv && pc == 8'd2) m_en_rd   = (pcode == 8'd73);
    if (pv && pc == 8'd3) m_en_wr   = (pcode == 8'd73);
    if (pv && pc == 8'd4) m_en_beat = (pcode == 8'd73);
  endtask

  task automatic idle_rd(input string tag, input logic sel);
    step(tag, 0, sel, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    logic [2:0] got;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() != 0) begin
        e = q.pop_front();
        got = {rd_txn_hit, wr_txn_hit, rd_beat_hit};
        checks++;
        if (got !== e.hits || cfg_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s: hits=%b rdata=%h expected hits=%b rdata=%h",
                   e.tag, got, cfg_rdata, e.hits, e.rdata);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle_rd("R1", 0);
    step("R1", 0, 1, 0, 0, 0, 0, 1, 1, 18'h0, 1, 1, 18'h0, 1, 1, 18'h0);
    // R9 write word0 with a strobe in the same cycle (old settings: off)
    step("R9", 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 1, 1, 18'h0, 0, 0, 0, 0, 0, 0);
    idle_rd("R2", 0);
    // R2 / R9 match ID write; strobe in write cycle compares against old ID 0
    step("R9", 1, 1, 32'hFFFC_1234, 0, 0, 0, 1, 1, 18'h01234, 0, 0, 0, 0, 0, 0);
    idle_rd("R2", 1);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 1, 18'h01234, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 18'h01234, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 1, 18'h01235, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 18'h01234, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 18'h01234, 0, 0, 0);
    // R6 back-to-back beats and one stalled beat
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 18'h01234);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 18'h01234);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 18'h01234);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 18'h01234);
    // R3 partial mask: only low byte compared
    step("R3", 1, 0, 32'hE000_00FF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 1, 1, 18'h3FF34, 1, 1, 18'h00034, 1, 1, 18'h12335);
    step("R3", 0, 0, 0, 0, 0, 0, 1, 1, 18'h2AB35, 1, 1, 18'h3FF34, 1, 1, 18'h00134);
    // R3 zero mask: everything matches
    step("R3", 1, 0, 32'hE000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 1, 1, 18'h2BCDE, 1, 1, 18'h3FFFF, 1, 1, 18'h00001);
    // R8 counter programming
    step("R8", 0, 0, 0, 1, 8'd2, 8'd5, 1, 1, 18'h0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1, 18'h0, 1, 1, 18'h0, 1, 1, 18'h0);
    step("R8", 0, 0, 0, 1, 8'd3, 8'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 8'd4, 8'd72, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1, 18'h0, 1, 1, 18'h0, 1, 1, 18'h0);
    step("R8", 0, 0, 0, 1, 8'd7, 8'd73, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 8'd1, 8'd73, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 8'd3, 8'd73, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 1, 18'h0, 1, 1, 18'h0, 1, 1, 18'h0);
    step("R8", 0, 0, 0, 1, 8'd2, 8'd73, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 8'd4, 8'd73, 1, 1, 18'h0, 1, 1, 18'h0, 1, 1, 18'h0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 1, 18'h0, 1, 1, 18'h0, 1, 1, 18'h0);
    // R10 simultaneous word write and programming
    step("R10", 1, 0, 32'h0000_0F0F, 1, 8'd2, 8'd73, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle_rd("R10", 0);
    step("R10", 1, 0, 32'hFFFF_FFFF, 1, 8'd4, 8'd9, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle_rd("R10", 0);
    // R7 all off via word write
    step("R7", 1, 0, 32'h0003_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1, 18'h01234, 1, 1, 18'h01234, 1, 1, 18'h01234);
    idle_rd("R2", 1);
    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_en_rd = 0; m_en_wr = 0; m_en_beat = 0; m_mask = '0; m_match = '0;
    idle_rd("R1", 0);
    idle_rd("R1", 1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule